// File: doc/BRIEF.md
# Serial Port Status Flags and Request Generator

This block holds the six status flags of a simple asynchronous serial port and turns them into interrupt requests and DMA trigger requests. The transmit and receive datapaths send it single-cycle event pulses: transmit buffer empty, transmit complete, receive buffer full, overrun, parity error and framing error. Each pulse sets its flag. Software clears a flag by reading the status register while the flag is 1 and then writing 0 to that bit. A DMA engine clears the data-ready flags as a side effect of moving data.

Three control enables gate four separate request lines. A fixed-priority encoder folds those lines into one combined request with a 2-bit source code. Only the two data-movement sources, transmit empty and receive full, drive the DMA trigger lines.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 6'b000011, meaning only the transmit-empty and transmit-complete flags are 1. All enables are 0, and every request output is low.
- R2: The status word has these bit positions: bit0 transmit empty, bit1 transmit complete, bit2 receive full, bit3 overrun, bit4 parity error, bit5 framing error. An event pulse sets its flag, and the flag shows on `stat_rdata` one cycle later.
- R3: A status write of 0 to a bit clears that flag only if a status read saw the flag at 1 since the last status write. A write of 0 with no such read leaves the flag set. A write of 1 never changes a flag.
- R4: Suppose a flag's event occurs after the arming read, or in the same cycle as the clearing write. The flag then stays 1, and a later write of 0 needs a fresh read.
- R5: A DMA write strobe to the transmit data register clears transmit empty in the next cycle. A DMA read strobe of the receive data register clears receive full in the next cycle. No CPU sequence is needed for either.
- R6: If an event pulse and a DMA clear reach the same flag in the same cycle, the flag ends up at 1.
- R7: Control write data bit0 is the transmit enable and gates `irq_txempty`. Bit1 is the receive enable and gates both `irq_rxfull` and `irq_rxerr`. Bit2 is the transmit-end enable and gates `irq_txend`. A new enable value acts in the cycle after the write.
- R8: `irq_rxerr` is high when the receive enable is set and at least one of overrun, parity error or framing error is 1.
- R9: `irq_valid` is high when any request line is high. `irq_code` then names the highest-priority active line: 0 receive error, 1 receive full, 2 transmit empty, 3 transmit end, with 0 as the highest.
- R10: `dma_tx_req` equals `irq_txempty` and `dma_rx_req` equals `irq_rxfull`. The receive-error and transmit-end sources never raise a DMA trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_empty | input | 1 | Transmit buffer free pulse |
| ev_tx_done | input | 1 | Frame fully shifted out pulse |
| ev_rx_full | input | 1 | Received byte ready pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_framing | input | 1 | Framing error pulse |
| stat_rd | input | 1 | CPU status register read strobe |
| stat_wr | input | 1 | CPU status register write strobe |
| stat_wdata | input | 6 | CPU status write data |
| ctrl_wr | input | 1 | CPU control register write strobe |
| ctrl_wdata | input | 3 | Enables: bit0 transmit, bit1 receive, bit2 transmit end |
| dma_tx_wr | input | 1 | DMA write to transmit data register |
| dma_rx_rd | input | 1 | DMA read of receive data register |
| stat_rdata | output | 6 | Current status flags |
| irq_rxerr | output | 1 | Receive error request |
| irq_rxfull | output | 1 | Receive full request |
| irq_txempty | output | 1 | Transmit empty request |
| irq_txend | output | 1 | Transmit end request |
| irq_valid | output | 1 | Combined request valid |
| irq_code | output | 2 | Source code of combined request |
| dma_tx_req | output | 1 | DMA trigger for transmit |
| dma_rx_req | output | 1 | DMA trigger for receive |

## Verification
The hardest situation to reach from the ports is a race against the clear handshake. One case is a flag that is set again between the arming read and the clearing write. The other is an event that lands in the same cycle as a DMA clear or as the CPU write. Directed sequences build these cases on purpose: read, re-pulse, then write 0, and event pulses aligned with `dma_rx_rd`, `dma_tx_wr` or `stat_wr`. A long random phase then drives events, reads, writes and DMA strobes at high rates. Throughout, a behavioural model compares every output on every clock.

// File: rtl/sio_irq_pkg.sv
// Package: shared constants for the serial port request logic.
// Assumes a fixed six-flag status layout that software decodes by bit.
package sio_irq_pkg;
    localparam int FLAG_W = 6;
    localparam int EN_W   = 3;
    localparam int SRC_N  = 4;
    localparam int CODE_W = $clog2(SRC_N);

    // status bit positions (software decodes these)
    localparam int F_TXE = 0;
    localparam int F_TXC = 1;
    localparam int F_RXF = 2;
    localparam int F_OVR = 3;
    localparam int F_PAR = 4;
    localparam int F_FRM = 5;

    // enable bit positions
    localparam int E_TX  = 0;
    localparam int E_RX  = 1;
    localparam int E_TE  = 2;

    // reset value: transmitter idle, buffer free
    localparam logic [FLAG_W-1:0] FLAG_RST = 6'b000011;

    // request source index doubles as the priority code (0 = highest)
    typedef enum logic [CODE_W-1:0] {
        SRC_RXERR  = 2'd0,
        SRC_RXFULL = 2'd1,
        SRC_TXE    = 2'd2,
        SRC_TXEND  = 2'd3
    } src_e;
endpackage

// File: rtl/sio_flag_bank.sv
// Module: sio_flag_bank
// Holds the status flags. Each bit is set by an event pulse. The CPU clears
// a bit with read-while-1 then write-0, and a DMA strobe can also clear it.
// Priority per bit: set event, then clear, then arming read, then disarm on write.
// Assumes the event pulses and strobes are synchronous to clk.
module sio_flag_bank #(
    parameter int W = 6,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] dma_clr,
    input  logic         rd,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags
);
    logic [W-1:0] flag_q;
    logic [W-1:0] arm_q;

    assign flags = flag_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic cpu_clr;
        assign cpu_clr = wr && !wdata[i] && arm_q[i];

        // per-bit flag and read-arm update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= RST_VAL[i];
                arm_q[i]  <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
                arm_q[i]  <= 1'b0;
            end else if (cpu_clr || dma_clr[i]) begin
                flag_q[i] <= 1'b0;
                arm_q[i]  <= 1'b0;
            end else if (rd && flag_q[i]) begin
                arm_q[i]  <= 1'b1;
            end else if (wr) begin
                arm_q[i]  <= 1'b0;
            end
        end

        assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flag_q[i]);
        assert_no_blind_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !arm_q[i] && !dma_clr[i]) |=> flag_q[i]);
        assert_dma_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_clr[i] && !set_ev[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/sio_req_gate.sv
// Module: sio_req_gate
// Holds the enable register. Gates the flags into the four request lines
// and the two DMA triggers. Assumes the package flag and enable layout.
module sio_req_gate
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [EN_W-1:0]   ctrl_wdata,
    input  logic [FLAG_W-1:0] flags,
    output logic [SRC_N-1:0]  req,
    output logic              dma_tx,
    output logic              dma_rx
);
    logic [EN_W-1:0] en_q;

    // enable register load
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (ctrl_wr) en_q <= ctrl_wdata;
    end

    // request lines, indexed by priority code
    always_comb begin
        req             = '0;
        req[SRC_RXERR]  = en_q[E_RX] && (flags[F_OVR] || flags[F_PAR] || flags[F_FRM]);
        req[SRC_RXFULL] = en_q[E_RX] && flags[F_RXF];
        req[SRC_TXE]    = en_q[E_TX] && flags[F_TXE];
        req[SRC_TXEND]  = en_q[E_TE] && flags[F_TXC];
    end

    // only the data-movement sources may trigger DMA
    assign dma_tx = req[SRC_TXE];
    assign dma_rx = req[SRC_RXFULL];

    assert_dma_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tx |-> flags[F_TXE]) and (dma_rx |-> flags[F_RXF]));
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata == '0) |=> (req == '0));
endmodule

// File: rtl/sio_prio_enc.sv
// Module: sio_prio_enc
// Fixed-priority encoder. The lowest set index wins. Purely combinational.
module sio_prio_enc #(
    parameter int N = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [CW-1:0] code
);
    // scan from lowest priority up so the highest-priority index is written last
    always_comb begin
        valid = |req;
        code  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = i[CW-1:0];
        end
    end
endmodule

// File: rtl/sio_irq_ctrl.sv
// Module: sio_irq_ctrl (top)
// Status flags, enables, separate and combined interrupt requests, and DMA
// triggers for a simple asynchronous serial port. Assumes one-cycle event
// pulses and one-cycle CPU/DMA strobes, all synchronous to clk.
module sio_irq_ctrl
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_done,
    input  logic              ev_rx_full,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [FLAG_W-1:0] stat_wdata,
    input  logic              ctrl_wr,
    input  logic [EN_W-1:0]   ctrl_wdata,
    input  logic              dma_tx_wr,
    input  logic              dma_rx_rd,
    output logic [FLAG_W-1:0] stat_rdata,
    output logic              irq_rxerr,
    output logic              irq_rxfull,
    output logic              irq_txempty,
    output logic              irq_txend,
    output logic              irq_valid,
    output logic [CODE_W-1:0] irq_code,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    logic [FLAG_W-1:0] set_ev;
    logic [FLAG_W-1:0] dma_clr;
    logic [FLAG_W-1:0] flags;
    logic [SRC_N-1:0]  req;

    // gather event pulses and DMA clears into flag-position vectors
    always_comb begin
        set_ev         = '0;
        set_ev[F_TXE]  = ev_tx_empty;
        set_ev[F_TXC]  = ev_tx_done;
        set_ev[F_RXF]  = ev_rx_full;
        set_ev[F_OVR]  = ev_overrun;
        set_ev[F_PAR]  = ev_parity;
        set_ev[F_FRM]  = ev_framing;
        dma_clr        = '0;
        dma_clr[F_TXE] = dma_tx_wr;
        dma_clr[F_RXF] = dma_rx_rd;
    end

    sio_flag_bank #(.W(FLAG_W), .RST_VAL(FLAG_RST)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .dma_clr(dma_clr),
        .rd(stat_rd), .wr(stat_wr), .wdata(stat_wdata), .flags(flags)
    );

    sio_req_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .flags(flags), .req(req), .dma_tx(dma_tx_req), .dma_rx(dma_rx_req)
    );

    sio_prio_enc #(.N(SRC_N)) u_prio (
        .req(req), .valid(irq_valid), .code(irq_code)
    );

    assign stat_rdata  = flags;
    assign irq_rxerr   = req[SRC_RXERR];
    assign irq_rxfull  = req[SRC_RXFULL];
    assign irq_txempty = req[SRC_TXE];
    assign irq_txend   = req[SRC_TXEND];

    assert_rxerr_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxerr |-> (irq_valid && irq_code == CODE_W'(SRC_RXERR)));
    assert_code_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> req[irq_code]);
    assert_err_from_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxerr |-> (stat_rdata[F_OVR] || stat_rdata[F_PAR] || stat_rdata[F_FRM]));
endmodule

// File: tb/sim_sio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sio_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic rd = 1'b0, wr = 1'b0, cw = 1'b0, dw = 1'b0, dr = 1'b0;
    logic [5:0] wd = '0;
    logic [2:0] cd = '0;
    logic [5:0] stat;
    logic i_err, i_rxf, i_txe, i_te, i_v, d_tx, d_rx;
    logic [1:0] i_code;
    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    bit m_flag[6];
    bit m_arm[6];
    bit m_en[3];

    always #5 clk = ~clk;

    sio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_empty(ev[0]), .ev_tx_done(ev[1]), .ev_rx_full(ev[2]),
        .ev_overrun(ev[3]), .ev_parity(ev[4]), .ev_framing(ev[5]),
        .stat_rd(rd), .stat_wr(wr), .stat_wdata(wd),
        .ctrl_wr(cw), .ctrl_wdata(cd), .dma_tx_wr(dw), .dma_rx_rd(dr),
        .stat_rdata(stat), .irq_rxerr(i_err), .irq_rxfull(i_rxf),
        .irq_txempty(i_txe), .irq_txend(i_te), .irq_valid(i_v),
        .irq_code(i_code), .dma_tx_req(d_tx), .dma_rx_req(d_rx)
    );

    // behavioural model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flag[i]) begin m_flag[i] = (i < 2); m_arm[i] = 0; end
            foreach (m_en[i]) m_en[i] = 0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                bit dclr;
                dclr = (i == 0 && dw) || (i == 2 && dr);
                if (ev[i]) begin m_flag[i] = 1; m_arm[i] = 0; end
                else if (dclr || (wr && !wd[i] && m_arm[i])) begin m_flag[i] = 0; m_arm[i] = 0; end
                else if (rd && m_flag[i]) m_arm[i] = 1;
                else if (wr) m_arm[i] = 0;
            end
            if (cw) for (int i = 0; i < 3; i++) m_en[i] = cd[i];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against the model every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int s, e[4], code, v;
            s = 0;
            for (int i = 0; i < 6; i++) s |= int'(m_flag[i]) << i;
            e[0] = m_en[1] && (m_flag[3] || m_flag[4] || m_flag[5]);
            e[1] = m_en[1] && m_flag[2];
            e[2] = m_en[0] && m_flag[0];
            e[3] = m_en[2] && m_flag[1];
            v = e[0] || e[1] || e[2] || e[3];
            code = 0;
            for (int i = 3; i >= 0; i--) if (e[i]) code = i;
            chk("R2 stat", stat, s);
            chk("R8 irq_rxerr", i_err, e[0]);
            chk("R7 irq_rxfull", i_rxf, e[1]);
            chk("R7 irq_txempty", i_txe, e[2]);
            chk("R7 irq_txend", i_te, e[3]);
            chk("R9 irq_valid", i_v, v);
            if (v) chk("R9 irq_code", i_code, code);
            chk("R10 dma_tx_req", d_tx, e[2]);
            chk("R10 dma_rx_req", d_rx, e[1]);
        end
    end

    task automatic cyc(input logic [5:0] e, input logic r, input logic w,
                       input logic [5:0] wdv, input logic c, input logic [2:0] cdv,
                       input logic dwv, input logic drv);
        @(posedge clk); #2;
        ev = e; rd = r; wr = w; wd = wdv; cw = c; cd = cdv; dw = dwv; dr = drv;
    endtask

    task automatic idle();
        cyc('0, 0, 0, '0, 0, '0, 0, 0);
    endtask

    task automatic look(input string tag, input int bitn, input int exp);
        @(negedge clk);
        chk(tag, stat[bitn], exp);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        done = 1;
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset stat", stat, 6'b000011);
        chk("R1 reset irq", {i_err, i_rxf, i_txe, i_te, i_v, d_tx, d_rx}, 0);
        // enable all sources
        cyc('0, 0, 0, '0, 1, 3'b111, 0, 0); idle();
        @(negedge clk); chk("R7 txempty after enable", i_txe, 1);
        // receive full, then parity error takes priority
        cyc(6'b000100, 0, 0, '0, 0, '0, 0, 0); idle();
        @(negedge clk); chk("R9 code rxfull over txe", i_code, 1);
        cyc(6'b010000, 0, 0, '0, 0, '0, 0, 0); idle();
        @(negedge clk); chk("R8 parity raises rxerr", i_err, 1);
        chk("R9 code rxerr", i_code, 0);
        // write 0 without arming read: no clear
        cyc('0, 0, 1, 6'b101111, 0, '0, 0, 0); idle();
        look("R3 blind write keeps parity", 4, 1);
        // proper clear of parity; a write of 1 keeps rxf
        cyc('0, 1, 0, '0, 0, '0, 0, 0);
        cyc('0, 0, 1, 6'b101111, 0, '0, 0, 0); idle();
        look("R3 read-then-write clears parity", 4, 0);
        look("R3 write 1 keeps rxfull", 2, 1);
        // set between read and write survives
        cyc('0, 1, 0, '0, 0, '0, 0, 0);
        cyc(6'b000100, 0, 0, '0, 0, '0, 0, 0);
        cyc('0, 0, 1, 6'b111011, 0, '0, 0, 0); idle();
        look("R4 reset-after-read survives", 2, 1);
        // set in same cycle as clearing write
        cyc('0, 1, 0, '0, 0, '0, 0, 0);
        cyc(6'b000100, 0, 1, 6'b111011, 0, '0, 0, 0); idle();
        look("R4 set with write survives", 2, 1);
        // DMA clears
        cyc('0, 0, 0, '0, 0, '0, 0, 1); idle();
        look("R5 dma read clears rxfull", 2, 0);
        cyc('0, 0, 0, '0, 0, '0, 1, 0); idle();
        look("R5 dma write clears txempty", 0, 0);
        // set and DMA clear together
        cyc(6'b000100, 0, 0, '0, 0, '0, 0, 1); idle();
        look("R6 set beats dma clear rx", 2, 1);
        cyc(6'b000001, 0, 0, '0, 0, '0, 1, 0); idle();
        look("R6 set beats dma clear tx", 0, 1);
        // enables individually
        cyc(6'b001000, 0, 0, '0, 1, 3'b000, 0, 0); idle();
        @(negedge clk); chk("R7 all disabled", i_v, 0);
        chk("R10 no dma when disabled", {d_tx, d_rx}, 0);
        cyc('0, 0, 0, '0, 1, 3'b100, 0, 0); idle();
        @(negedge clk); chk("R9 only txend code", i_code, 3);
        chk("R10 txend no dma", {d_tx, d_rx}, 0);
        cyc('0, 0, 0, '0, 1, 3'b010, 0, 0); idle();
        @(negedge clk); chk("R7 rx enable gates rxerr", i_err, 1);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [5:0] re;
            re = 6'($urandom) & 6'($urandom);
            cyc(re, 1'($urandom), ($urandom % 3) == 0, 6'($urandom),
                ($urandom % 16) == 0, 3'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        idle(); idle();
        @(negedge clk);
        done = 1;
        summary();
    end
endmodule